// File: doc/BRIEF.md
# DMA Channel Address Tracker

This block keeps the address state for one side of a DMA channel. It holds a programmed start address and a working address. Software loads the start address while the channel is idle, or a linked-list descriptor update loads it before the block begins. Starting the channel copies the start address, aligned to a doubleword, into the working address. The working address is the request address for the next read burst.

Each time a read burst is accepted on the bus, the block records the burst's first address. If the channel's increment mode was chosen at start, the working address moves forward by the burst length times four bytes. In fixed mode it stays where it is. Decrementing is not offered.

The readback port reports one of two values:
- While the channel is enabled and at least one read has been issued, it shows the first address of the newest accepted burst.
- Otherwise it shows the programmed start value.

A block-done pulse disables the channel. From the next cycle the readback shows the start value again.

Top module: `dma_addr_track`

## Requirements
- R1: After reset the programmed address is 00000000h, `ch_en` is 0, and both `rdback` and `rd_req_addr` read 0.
- R2: While `ch_en` is 0, a pulse on `sw_wr_en` stores `sw_wr_addr`. From the next cycle `rdback` shows the stored value in full.
- R3: When `desc_ld_en` and `sw_wr_en` are both high in an idle cycle, the descriptor address is stored and the software address is dropped.
- R4: While `ch_en` is 1, software writes and descriptor loads are ignored. The programmed value shown later by `rdback` is unchanged.
- R5: `ch_start` in an idle cycle sets `ch_en` from the next cycle and captures `incr_mode` for the run. Until the first read is accepted, `rdback` shows the programmed address.
- R6: When a burst is accepted (`ch_en`, `rd_req_valid` and `rd_req_ready` all 1), `rdback` shows that burst's request address from the next cycle. This is its first beat, not any later beat.
- R7: In increment mode, each accepted burst of `rd_req_len` beats advances `rd_req_addr` by `rd_req_len`*4 from the next cycle.
- R8: In fixed mode (`incr_mode` 0 at start), `rd_req_addr` does not change across accepted bursts.
- R9: `rd_req_addr` and the live readback always have bits [1:0] equal to 0. The programmed value shown while disabled keeps its low bits.
- R10: `blk_done` while enabled clears `ch_en` at the next edge. From that cycle `rdback` shows the programmed start address.
- R11: A request that is valid without ready, or any request while the channel is disabled, leaves `rd_req_addr` and `rdback` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr_en | input | 1 | Software write strobe for the start address |
| sw_wr_addr | input | 32 | Software write data |
| desc_ld_en | input | 1 | Linked-list descriptor load strobe |
| desc_ld_addr | input | 32 | Descriptor start address |
| ch_start | input | 1 | Enable the channel (idle only) |
| incr_mode | input | 1 | 1 = increment, 0 = fixed; captured at start |
| blk_done | input | 1 | Block complete, disables the channel |
| rd_req_valid | input | 1 | Read burst request presented |
| rd_req_ready | input | 1 | Bus accepts the read burst |
| rd_req_len | input | LEN_W | Burst length in beats |
| rd_req_addr | output | 32 | Doubleword-aligned address of the next burst |
| ch_en | output | 1 | Channel enable state |
| rdback | output | 32 | Register readback value |

## Verification
All outputs come from registers. Every effect of a strobe or of an accepted burst is therefore due exactly one clock edge later: a load, a start, a burst acceptance or a done pulse. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. Each result is checked in the cycle it first becomes valid. Checks on ignored stimulus sample in that same next cycle, before any other stimulus arrives.

// File: rtl/dma_at_pkg.sv
package dma_at_pkg;
    parameter int unsigned AT_ADDR_W = 32;
    parameter int unsigned AT_BEAT_BYTES = 4;
    localparam int unsigned AT_ALIGN_BITS = $clog2(AT_BEAT_BYTES);

    typedef logic [AT_ADDR_W-1:0] at_addr_t;

    typedef struct packed {
        at_addr_t prog;   // programmed start address
        at_addr_t work;   // next request address
        at_addr_t last;   // first address of newest accepted burst
        logic     seen;   // a burst was accepted in this run
        logic     en;     // channel enabled
        logic     incr;   // increment mode for this run
    } at_state_t;

    function automatic at_addr_t at_align(input at_addr_t a);
        at_addr_t m;
        m = '1;
        m[AT_ALIGN_BITS-1:0] = '0;
        return a & m;
    endfunction
endpackage

// File: rtl/dma_at_step.sv
module dma_at_step
    import dma_at_pkg::*;
#(
    parameter int unsigned LEN_W = 4
) (
    input  at_addr_t         base,
    input  logic [LEN_W-1:0] len,
    input  logic             incr,
    output at_addr_t         next
);
    localparam int unsigned PAD_W = AT_ADDR_W - LEN_W;

    at_addr_t span;

    always_comb begin
        span = {{PAD_W{1'b0}}, len} << AT_ALIGN_BITS;
        next = incr ? (base + span) : base;
    end
endmodule

// File: rtl/dma_at_rbmux.sv
module dma_at_rbmux
    import dma_at_pkg::*;
(
    input  logic     en,
    input  logic     seen,
    input  at_addr_t live,
    input  at_addr_t prog,
    output at_addr_t value
);
    always_comb begin
        value = (en && seen) ? live : prog;
    end
endmodule

// File: rtl/dma_addr_track.sv
module dma_addr_track
    import dma_at_pkg::*;
#(
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [31:0]      sw_wr_addr,
    input  logic             desc_ld_en,
    input  logic [31:0]      desc_ld_addr,
    input  logic             ch_start,
    input  logic             incr_mode,
    input  logic             blk_done,
    input  logic             rd_req_valid,
    input  logic             rd_req_ready,
    input  logic [LEN_W-1:0] rd_req_len,
    output logic [31:0]      rd_req_addr,
    output logic             ch_en,
    output logic [31:0]      rdback
);
    at_state_t s_d, s_q;
    at_addr_t  step_next;
    logic      accept;

    dma_at_step #(.LEN_W(LEN_W)) u_step (
        .base (s_q.work),
        .len  (rd_req_len),
        .incr (s_q.incr),
        .next (step_next)
    );

    dma_at_rbmux u_rbmux (
        .en    (s_q.en),
        .seen  (s_q.seen),
        .live  (s_q.last),
        .prog  (s_q.prog),
        .value (rdback)
    );

    always_comb begin
        s_d    = s_q;
        accept = s_q.en && rd_req_valid && rd_req_ready;
        if (!s_q.en) begin
            // descriptor load has priority over software write
            if (desc_ld_en) begin
                s_d.prog = desc_ld_addr;
            end else if (sw_wr_en) begin
                s_d.prog = sw_wr_addr;
            end
            if (desc_ld_en || sw_wr_en || ch_start) begin
                s_d.work = at_align(s_d.prog);
            end
            if (ch_start) begin
                s_d.en   = 1'b1;
                s_d.incr = incr_mode;
                s_d.seen = 1'b0;
            end
        end else if (blk_done) begin
            s_d.en   = 1'b0;
            s_d.seen = 1'b0;
        end else if (accept) begin
            s_d.last = s_q.work;
            s_d.seen = 1'b1;
            s_d.work = step_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req_addr = s_q.work;
    assign ch_en       = s_q.en;
endmodule

// File: rtl/dma_addr_track_chk.sv
module dma_addr_track_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        blk_done,
    input logic        rd_req_valid,
    input logic        rd_req_ready,
    input logic        ch_en,
    input logic [31:0] rd_req_addr,
    input logic [31:0] rdback,
    input logic [31:0] prog_q,
    input logic        incr_q
);
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_addr[1:0] == 2'b00); // R9

    AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en |=> $stable(prog_q)); // R4

    AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && blk_done) |=> (!ch_en && rdback == prog_q)); // R10

    AST_BURST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && !blk_done && rd_req_valid && rd_req_ready) |=> (rdback == $past(rd_req_addr))); // R6

    AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && !incr_q) |=> $stable(rd_req_addr)); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && !blk_done && rd_req_valid && !rd_req_ready) |=> ($stable(rd_req_addr) && $stable(rdback))); // R11
endmodule

bind dma_addr_track dma_addr_track_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .blk_done     (blk_done),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .ch_en        (ch_en),
    .rd_req_addr  (rd_req_addr),
    .rdback       (rdback),
    .prog_q       (s_q.prog),
    .incr_q       (s_q.incr)
);

// File: tb/dma_addr_track_tb_top.sv
module dma_addr_track_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sw_wr_en = 1'b0;
    logic [31:0]      sw_wr_addr = '0;
    logic             desc_ld_en = 1'b0;
    logic [31:0]      desc_ld_addr = '0;
    logic             ch_start = 1'b0;
    logic             incr_mode = 1'b0;
    logic             blk_done = 1'b0;
    logic             rd_req_valid = 1'b0;
    logic             rd_req_ready = 1'b0;
    logic [LEN_W-1:0] rd_req_len = '0;
    logic [31:0]      rd_req_addr;
    logic             ch_en;
    logic [31:0]      rdback;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_track #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(sw_wr_en), .sw_wr_addr(sw_wr_addr),
        .desc_ld_en(desc_ld_en), .desc_ld_addr(desc_ld_addr),
        .ch_start(ch_start), .incr_mode(incr_mode), .blk_done(blk_done),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_len(rd_req_len),
        .rd_req_addr(rd_req_addr), .ch_en(ch_en), .rdback(rdback)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // apply strobes at negedge, pass one rising edge, return at next negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        sw_wr_en = 0; desc_ld_en = 0; ch_start = 0; blk_done = 0;
        rd_req_valid = 0; rd_req_ready = 0;
    endtask

    task automatic t_reset();
        chk("R1", "ch_en", {31'd0, ch_en}, 32'd0);
        chk("R1", "rdback", rdback, 32'h0);
        chk("R1", "rd_req_addr", rd_req_addr, 32'h0);
    endtask

    task automatic t_sw_load();
        sw_wr_en = 1; sw_wr_addr = 32'h1000_0013;
        tick();
        chk("R2", "rdback after write", rdback, 32'h1000_0013);
        chk("R9", "aligned req addr", rd_req_addr, 32'h1000_0010);
    endtask

    task automatic t_priority();
        desc_ld_en = 1; desc_ld_addr = 32'h2000_0000;
        sw_wr_en = 1; sw_wr_addr = 32'h3000_0000;
        tick();
        chk("R3", "descriptor wins", rdback, 32'h2000_0000);
    endtask

    task automatic t_start_incr();
        ch_start = 1; incr_mode = 1;
        tick();
        chk("R5", "ch_en set", {31'd0, ch_en}, 32'd1);
        chk("R5", "rdback before read", rdback, 32'h2000_0000);
        sw_wr_en = 1; sw_wr_addr = 32'h5555_0000;
        desc_ld_en = 1; desc_ld_addr = 32'h6666_0000;
        tick();
        chk("R4", "write ignored when enabled", rdback, 32'h2000_0000);
        chk("R4", "req addr unchanged", rd_req_addr, 32'h2000_0000);
        rd_req_valid = 1; rd_req_ready = 0; rd_req_len = 4;
        tick();
        chk("R11", "stall addr", rd_req_addr, 32'h2000_0000);
        chk("R11", "stall rdback", rdback, 32'h2000_0000);
        rd_req_valid = 1; rd_req_ready = 1; rd_req_len = 4;
        tick();
        chk("R6", "rdback first burst", rdback, 32'h2000_0000);
        chk("R7", "advance by 16", rd_req_addr, 32'h2000_0010);
        rd_req_valid = 1; rd_req_ready = 1; rd_req_len = 8;
        tick();
        chk("R6", "rdback second burst", rdback, 32'h2000_0010);
        chk("R7", "advance by 32", rd_req_addr, 32'h2000_0030);
        blk_done = 1;
        tick();
        chk("R10", "ch_en cleared", {31'd0, ch_en}, 32'd0);
        chk("R10", "rdback reverts", rdback, 32'h2000_0000);
        rd_req_valid = 1; rd_req_ready = 1; rd_req_len = 5;
        tick();
        chk("R11", "disabled request addr", rd_req_addr, 32'h2000_0030);
        chk("R11", "disabled request rdback", rdback, 32'h2000_0000);
    endtask

    task automatic t_fixed();
        sw_wr_en = 1; sw_wr_addr = 32'h4000_0102;
        ch_start = 1; incr_mode = 0;
        tick();
        chk("R5", "start with same-cycle load", rd_req_addr, 32'h4000_0100);
        for (int i = 0; i < 2; i++) begin
            rd_req_valid = 1; rd_req_ready = 1; rd_req_len = 3;
            tick();
            chk("R8", "fixed req addr", rd_req_addr, 32'h4000_0100);
            chk("R9", "live readback aligned", rdback, 32'h4000_0100);
        end
        blk_done = 1;
        tick();
        chk("R10", "revert to programmed", rdback, 32'h4000_0102);
        chk("R9", "programmed keeps low bits", {30'd0, rdback[1:0]}, 32'd2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sw_load();
        t_priority();
        t_start_incr();
        t_fixed();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule